// File: doc/BRIEF.md
# Descriptor Reference Ring Controller

This block keeps one circular queue of descriptor references in an external memory region. Software sets four pointers through a small register port: the first slot and the last slot of the region, the producer position and the consumer position. It also sets the base of a descriptor table. A producer strobes a 14-bit reference in, and a consumer strobes a request to take the oldest reference out. Each operation turns into one access on a request/acknowledge memory port.

The two sides step their pointers differently. The producer stores at its current position and then moves on. The consumer first moves on, with wrap, and then reads the slot it has reached. A reference that comes out is an entry number into a descriptor table of 32-byte records. The block adds that number, scaled, to the programmed table base and reports the descriptor's byte address with the reference. Full and empty flags come from the pointers. A request that the queue cannot serve is refused, and the refusal shows as a one-cycle pulse.

Top module: `desc_ref_ring`

## Requirements
- R1: After reset the block has busy, mem_req, refuse, push_done and pop_done all low.
- R2: A cycle with cfg_we high loads cfg_wdata into the register chosen by cfg_sel: 0 = region start slot, 1 = region end slot, 2 = write pointer, 3 = read pointer (each taking the low ADDR_W bits), 4 = descriptor table base (all BASE_W bits).
- R3: An accepted push makes one memory write (mem_we = 1) of push_ref at the current write pointer. After the acknowledge, the write pointer moves to the next slot and push_done pulses for one cycle.
- R4: An accepted pop makes one memory read (mem_we = 0) at the read pointer advanced by one slot. After the acknowledge, the read pointer takes that slot.
- R5: A pointer that advances from the end slot goes to the start slot, and from any other slot goes to slot + 1.
- R6: empty is high when the read pointer advanced by one slot equals the write pointer. full is high when the write pointer equals the read pointer.
- R7: A push presented while full makes no memory access and raises refuse in the following cycle for one cycle.
- R8: A pop presented while empty makes no memory access and raises refuse in the following cycle for one cycle.
- R9: A completed pop pulses pop_done for one cycle. pop_ref then carries the data read, and pop_desc_addr carries the table base + pop_ref × 32.
- R10: Only one memory access is outstanding at a time. While busy, push_req and pop_req are ignored, and mem_req, mem_addr and mem_wdata hold steady until mem_ack.
- R11: When push_req and pop_req arrive in the same idle cycle, the push is served and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | BASE_W | Register write value |
| push_req | input | 1 | Push strobe, sampled while idle |
| push_ref | input | REF_W | Reference to store |
| pop_req | input | 1 | Pop strobe, sampled while idle |
| busy | output | 1 | A memory access is outstanding |
| full | output | 1 | No free slot |
| empty | output | 1 | No stored reference |
| refuse | output | 1 | One-cycle pulse for a refused request |
| push_done | output | 1 | Push completed |
| pop_done | output | 1 | Pop completed, result valid |
| pop_ref | output | REF_W | Reference taken out |
| pop_desc_addr | output | BASE_W | Descriptor byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Slot address |
| mem_wdata | output | REF_W | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | REF_W | Read data, valid with mem_ack |

## Verification
The ring is set up so that the read pointer sits on the end slot. The first pop therefore has to wrap to the start, and a later push runs the write pointer off the end. Both wrap paths are covered this way. Filling to capacity and draining to nothing test the full and empty conditions, including a push refused at full and a pop refused at empty. Neither refusal may touch memory. References with all bits set, zero and mixed patterns are used, and acknowledge latencies vary from zero to three cycles. Together they separate bad data paths, bad table-address scaling and pointer slips. Strobes sent while busy, and a push together with a pop, test the serialisation and the priority between the two sides.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_END   = 3'd1,
    SEL_WPTR  = 3'd2,
    SEL_RPTR  = 3'd3,
    SEL_BASE  = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } ring_st_e;
endpackage

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] nxt
);
  // wrap from the last slot back to the first
  always_comb begin
    if (cur == last) nxt = first;
    else             nxt = cur + AW'(1);
  end
endmodule

// File: rtl/ring_addr_xlate.sv
module ring_addr_xlate #(
  parameter int REF_W      = 14,
  parameter int BASE_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic [BASE_W-1:0] base,
  input  logic [REF_W-1:0]  ref_in,
  output logic [BASE_W-1:0] addr
);
  localparam int SH = $clog2(DESC_BYTES);
  logic [BASE_W-1:0] offs;
  always_comb begin
    offs = BASE_W'({ref_in, {SH{1'b0}}});
    addr = base + offs;
  end
endmodule

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
  import ring_pkg::*;
#(
  parameter int AW     = 10,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [BASE_W-1:0] cfg_wdata,
  input  logic              wadv,
  input  logic [AW-1:0]     wptr_nxt,
  input  logic              radv,
  input  logic [AW-1:0]     rptr_nxt,
  output logic [AW-1:0]     first_q,
  output logic [AW-1:0]     last_q,
  output logic [AW-1:0]     wptr_q,
  output logic [AW-1:0]     rptr_q,
  output logic [BASE_W-1:0] base_q
);
  logic          en_first, en_last, en_w, en_r, en_base;
  logic [AW-1:0] w_d, r_d;

  always_comb begin
    en_first = cfg_we && (cfg_sel == SEL_START);
    en_last  = cfg_we && (cfg_sel == SEL_END);
    en_base  = cfg_we && (cfg_sel == SEL_BASE);
    en_w     = (cfg_we && (cfg_sel == SEL_WPTR)) || wadv;
    en_r     = (cfg_we && (cfg_sel == SEL_RPTR)) || radv;
    w_d      = (cfg_we && (cfg_sel == SEL_WPTR)) ? cfg_wdata[AW-1:0] : wptr_nxt;
    r_d      = (cfg_we && (cfg_sel == SEL_RPTR)) ? cfg_wdata[AW-1:0] : rptr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      base_q  <= '0;
    end else begin
      if (en_first) first_q <= cfg_wdata[AW-1:0];
      if (en_last)  last_q  <= cfg_wdata[AW-1:0];
      if (en_w)     wptr_q  <= w_d;
      if (en_r)     rptr_q  <= r_d;
      if (en_base)  base_q  <= cfg_wdata;
    end
  end
endmodule

// File: rtl/desc_ref_ring.sv
module desc_ref_ring
  import ring_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int REF_W      = 14,
  parameter int BASE_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [BASE_W-1:0] cfg_wdata,
  input  logic              push_req,
  input  logic [REF_W-1:0]  push_ref,
  input  logic              pop_req,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic              refuse,
  output logic              push_done,
  output logic              pop_done,
  output logic [REF_W-1:0]  pop_ref,
  output logic [BASE_W-1:0] pop_desc_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REF_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [REF_W-1:0]  mem_rdata
);
  logic [ADDR_W-1:0] first_q, last_q, wptr_q, rptr_q;
  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] wnext, rnext;
  logic [BASE_W-1:0] xl_addr;
  logic              wadv, radv;

  ring_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REF_W-1:0]  wdat_q, wdat_d;
  logic              ref_q, ref_d;
  logic              pshd_q, pshd_d;
  logic              popd_q, popd_d;
  logic [REF_W-1:0]  pref_q, pref_d;
  logic [BASE_W-1:0] padr_q, padr_d;
  logic              issue_en, res_en;

  ring_ptr_regs #(.AW(ADDR_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wadv(wadv), .wptr_nxt(wnext),
    .radv(radv), .rptr_nxt(addr_q), .first_q(first_q), .last_q(last_q),
    .wptr_q(wptr_q), .rptr_q(rptr_q), .base_q(base_q)
  );

  ring_ptr_step #(.AW(ADDR_W)) u_wstep (
    .cur(wptr_q), .first(first_q), .last(last_q), .nxt(wnext)
  );

  ring_ptr_step #(.AW(ADDR_W)) u_rstep (
    .cur(rptr_q), .first(first_q), .last(last_q), .nxt(rnext)
  );

  ring_addr_xlate #(.REF_W(REF_W), .BASE_W(BASE_W), .DESC_BYTES(DESC_BYTES)) u_xl (
    .base(base_q), .ref_in(mem_rdata), .addr(xl_addr)
  );

  always_comb begin
    full  = (wptr_q == rptr_q);
    empty = (rnext == wptr_q);
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    wdat_d   = wdat_q;
    ref_d    = 1'b0;
    pshd_d   = 1'b0;
    popd_d   = 1'b0;
    pref_d   = pref_q;
    padr_d   = padr_q;
    wadv     = 1'b0;
    radv     = 1'b0;
    issue_en = 1'b0;
    res_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (push_req) begin
          if (full) ref_d = 1'b1;
          else begin
            st_d     = ST_WR;
            addr_d   = wptr_q;
            wdat_d   = push_ref;
            issue_en = 1'b1;
          end
        end else if (pop_req) begin
          if (empty) ref_d = 1'b1;
          else begin
            st_d     = ST_RD;
            addr_d   = rnext;
            issue_en = 1'b1;
          end
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          wadv   = 1'b1;
          pshd_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_RD: begin
        if (mem_ack) begin
          radv   = 1'b1;
          popd_d = 1'b1;
          pref_d = mem_rdata;
          padr_d = xl_addr;
          res_en = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
      ref_q  <= 1'b0;
      pshd_q <= 1'b0;
      popd_q <= 1'b0;
      pref_q <= '0;
      padr_q <= '0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      pshd_q <= pshd_d;
      popd_q <= popd_d;
      if (issue_en) begin
        addr_q <= addr_d;
        wdat_q <= wdat_d;
      end
      if (res_en) begin
        pref_q <= pref_d;
        padr_q <= padr_d;
      end
    end
  end

  always_comb begin
    mem_req       = (st_q != ST_IDLE);
    mem_we        = (st_q == ST_WR);
    mem_addr      = addr_q;
    mem_wdata     = wdat_q;
    busy          = mem_req;
    refuse        = ref_q;
    push_done     = pshd_q;
    pop_done      = popd_q;
    pop_ref       = pref_q;
    pop_desc_addr = padr_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))) // R10
    else $error("request dropped or changed before acknowledge");

  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && push_req && full) |=> (!mem_req && refuse)) // R7
    else $error("push accepted while full");

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !push_req && pop_req && empty) |=> (!mem_req && refuse)) // R8
    else $error("pop accepted while empty");

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && push_req && pop_req && !full) |=> (mem_req && mem_we)) // R11
    else $error("pop served ahead of push");

  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (push_done && !busy)) // R3
    else $error("write acknowledge without completion");
endmodule

// File: tb/tb_desc_ref_ring.sv
module tb_desc_ref_ring;
  localparam int AW = 10;
  localparam int RW = 14;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [BW-1:0] cfg_wdata = '0;
  logic          push_req = 1'b0;
  logic [RW-1:0] push_ref = '0;
  logic          pop_req = 1'b0;
  logic          busy, full, empty, refuse, push_done, pop_done;
  logic [RW-1:0] pop_ref;
  logic [BW-1:0] pop_desc_addr;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [RW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [RW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  desc_ref_ring #(.ADDR_W(AW), .REF_W(RW), .BASE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .push_req(push_req), .push_ref(push_ref), .pop_req(pop_req),
    .busy(busy), .full(full), .empty(empty), .refuse(refuse),
    .push_done(push_done), .pop_done(pop_done), .pop_ref(pop_ref),
    .pop_desc_addr(pop_desc_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with programmable latency
  logic [RW-1:0] mem [0:(1<<AW)-1];
  int lat = 0;
  int wcnt = 0;
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr];
      end else wcnt <= wcnt + 1;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] last_waddr, last_raddr;
  logic [RW-1:0] last_wdata;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model of the pointers
  logic [AW-1:0] m_first, m_last, m_w, m_r;
  logic [BW-1:0] m_base;
  function automatic logic [AW-1:0] stepf(input logic [AW-1:0] p);
    return (p == m_last) ? m_first : p + AW'(1);
  endfunction

  logic [RW-1:0] exp_q[$];

  // memory access monitor
  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        wr_cnt++;
        last_waddr = mem_addr;
        last_wdata = mem_wdata;
      end else begin
        rd_cnt++;
        last_raddr = mem_addr;
      end
    end
  end

  // scoreboard monitor for pop results
  always @(negedge clk) begin
    if (rst_n && pop_done) begin
      logic [RW-1:0] e;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected pop", 32'(pop_ref), 32'hFFFF_FFFF);
      end else begin
        e = exp_q.pop_front();
        chk(pop_ref == e, "R9 pop_ref", 32'(pop_ref), 32'(e));
        chk(pop_desc_addr == m_base + (32'(e) << 5), "R9 desc addr",
            pop_desc_addr, m_base + (32'(e) << 5));
      end
    end
  end

  task automatic cfg(input logic [2:0] s, input logic [BW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_push(input logic [RW-1:0] r, input bit also_pop);
    bit was_full;
    int rc;
    int wc;
    @(negedge clk);
    wait_idle();
    was_full = (m_w == m_r);
    rc = rd_cnt; wc = wr_cnt;
    push_req = 1'b1; push_ref = r; pop_req = also_pop;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    if (was_full) begin
      chk(refuse == 1'b1, "R7 refuse on full", 32'(refuse), 32'd1);
      chk(mem_req == 1'b0, "R7 no access on full", 32'(mem_req), 32'd0);
      @(negedge clk);
      chk(refuse == 1'b0, "R7 refuse one cycle", 32'(refuse), 32'd0);
      chk(wr_cnt == wc, "R7 write count", 32'(wr_cnt), 32'(wc));
    end else begin
      while (!push_done) @(negedge clk);
      chk(last_waddr == m_w, "R3 write addr", 32'(last_waddr), 32'(m_w));
      chk(last_wdata == r, "R3 write data", 32'(last_wdata), 32'(r));
      chk(wr_cnt == wc + 1, "R3 one write", 32'(wr_cnt), 32'(wc + 1));
      if (also_pop) chk(rd_cnt == rc, "R11 pop dropped", 32'(rd_cnt), 32'(rc));
      m_w = stepf(m_w);
      exp_q.push_back(r);
    end
  endtask

  task automatic do_pop(input bit strobe_push_busy);
    bit was_empty;
    int rc;
    int wc;
    logic [AW-1:0] ea;
    @(negedge clk);
    wait_idle();
    was_empty = (stepf(m_r) == m_w);
    rc = rd_cnt; wc = wr_cnt;
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    if (was_empty) begin
      chk(refuse == 1'b1, "R8 refuse on empty", 32'(refuse), 32'd1);
      chk(mem_req == 1'b0, "R8 no access on empty", 32'(mem_req), 32'd0);
      @(negedge clk);
      chk(refuse == 1'b0, "R8 refuse one cycle", 32'(refuse), 32'd0);
      chk(rd_cnt == rc, "R8 read count", 32'(rd_cnt), 32'(rc));
    end else begin
      if (strobe_push_busy) begin
        push_req = 1'b1; push_ref = 14'h0AAA;
        @(negedge clk);
        push_req = 1'b0;
      end
      while (!pop_done) @(negedge clk);
      ea = stepf(m_r);
      chk(last_raddr == ea, "R4 read addr", 32'(last_raddr), 32'(ea));
      chk(rd_cnt == rc + 1, "R4 one read", 32'(rd_cnt), 32'(rc + 1));
      if (strobe_push_busy) chk(wr_cnt == wc, "R10 busy push ignored", 32'(wr_cnt), 32'(wc));
      m_r = ea;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(refuse == 1'b0 && push_done == 1'b0 && pop_done == 1'b0, "R1 pulses",
        {29'd0, refuse, push_done, pop_done}, 32'd0);

    m_first = 10'd4; m_last = 10'd11; m_w = 10'd4; m_r = 10'd11; m_base = 32'h1000_0040;
    cfg(3'd0, 32'(m_first));
    cfg(3'd1, 32'(m_last));
    cfg(3'd2, 32'(m_w));
    cfg(3'd3, 32'(m_r));
    cfg(3'd4, m_base);
    @(negedge clk);
    chk(empty == 1'b1, "R6 R2 empty after config", 32'(empty), 32'd1);
    chk(full == 1'b0, "R6 R2 not full", 32'(full), 32'd0);

    do_pop(1'b0);  // refused, R8

    for (int i = 0; i < 7; i++) begin
      lat = i % 4;
      do_push(RW'(14'h3FFF - 14'(i * 1111)), 1'b0);
    end
    lat = 0;
    do_push(14'h0000, 1'b0);  // refused, R7
    @(negedge clk);
    chk(full == 1'b1, "R6 full at capacity", 32'(full), 32'd1);

    lat = 3;
    do_pop(1'b1);  // first read wraps 11 -> 4 (R5), R10 strobe
    chk(m_r == 10'd4, "R5 read wrap", 32'(m_r), 32'd4);
    lat = 1;
    do_push(14'h0000, 1'b1);  // writes slot 11, R11
    chk(m_w == 10'd4, "R5 write wrap", 32'(m_w), 32'd4);
    @(negedge clk);
    chk(full == 1'b1, "R6 full after refill", 32'(full), 32'd1);

    for (int i = 0; i < 7; i++) begin
      lat = (i + 2) % 4;
      do_pop(1'b0);
    end
    @(negedge clk);
    chk(empty == 1'b1, "R6 empty after drain", 32'(empty), 32'd1);
    chk(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    do_pop(1'b0);  // refused again, R8

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule